// File: doc/BRIEF.md
# Multi-Channel Output Control Priority Decoder

This block decides, for each channel of a multi-channel deserializer, how the pad drivers of that channel behave. It looks at two scan test requests, a master power-down, a power-down for each channel, a shared output enable and each channel's lock flag. From these it produces, per channel, a drive enable and a forced-high override for the data bus and recovered clock, and a drive enable and level for the lock pin. It also produces a power-down signal for each channel and one for the shared bias circuits.

All control and lock inputs are asynchronous to the system clock. They pass through a two-flop synchroniser, and a single output register after the decode holds every result. The decode applies a fixed ranking. Scan requests come first, then the master power-down, then the channel power-down, then the output enable. When the output enable is low, the lock pin keeps reporting, so software can confirm lock before it turns the data drivers on. A channel that comes out of power-down is reported as unlocked until its lock flag has been seen rising again.

Top module: `outctl_prio`

## Requirements
- R1: Every input change reaches the outputs on the third rising clock edge after it is sampled: two synchroniser stages and one output register.
- R2: When `scan_hiz_ni` is low or `scan_bist_i` is high, `dat_oe_o` and `lck_oe_o` are all 0, whatever the other inputs are. In this state `dat_hi_o` reads 0 and `lck_o` reads 1.
- R3: When scan is idle and `mst_pwr_ni` is low, every channel has `dat_oe_o`=1, `dat_hi_o`=1, `lck_oe_o`=1 and `lck_o`=1.
- R4: When scan is idle, the master is awake and `ch_pwr_ni[i]` is low, channel i is forced as in R3. The other channels are not affected.
- R5: For an awake channel with `out_en_i` low, `dat_oe_o[i]`=0 and `lck_oe_o[i]`=1. `lck_o[i]` still reports lock: 0 when the channel is locked and 1 when it is not.
- R6: For an awake channel with `out_en_i` high, `dat_oe_o[i]`=1. An unlocked channel gives `dat_hi_o[i]`=1 and `lck_o[i]`=1. A locked channel gives `dat_hi_o[i]`=0, so data and clock pass through, and `lck_o[i]`=0. `lock_det_i[i]`=1 means the channel is locked.
- R7: `ch_pd_o[i]` is 1 exactly when `mst_pwr_ni` is low or `ch_pwr_ni[i]` is low. Scan requests and the output enable do not change it.
- R8: `bias_pd_o` is 1 when `mst_pwr_ni` is low, or when all `ch_pwr_ni` bits are low while the master is high.
- R9: While reset is held, and with all power-down and enable inputs low, every channel is asleep. Outputs are as in R3, with `ch_pd_o` all 1 and `bias_pd_o`=1.
- R10: When `out_en_i` returns high with the other inputs unchanged, each channel's outputs take back the values they had before the enable dropped.
- R11: A channel that has been powered down is treated as unlocked until its synchronised lock flag goes from 0 to 1 while the channel is awake. A lock flag that stays high through the power-down does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_hiz_ni | input | 1 | Scan high-impedance request, active low |
| scan_bist_i | input | 1 | Scan self-test request, active high |
| mst_pwr_ni | input | 1 | Master power control, low puts all channels to sleep |
| ch_pwr_ni | input | NUM_CH | Per-channel power control, low puts the channel to sleep |
| out_en_i | input | 1 | Data and clock output enable, active high |
| lock_det_i | input | NUM_CH | Per-channel lock flag, 1 = locked |
| dat_oe_o | output | NUM_CH | Drive enable for the data bus and clock pads |
| dat_hi_o | output | NUM_CH | Force the data bus and clock pads high |
| lck_oe_o | output | NUM_CH | Drive enable for the lock pad |
| lck_o | output | NUM_CH | Lock pad level, 0 = locked |
| ch_pd_o | output | NUM_CH | Channel power-down |
| bias_pd_o | output | 1 | Shared bias power-down |

## Verification
The bench sets scan requests on top of power-down and disable conditions, to show that the ranking holds. A design that ranked them wrongly would leave the lock pad driving during scan, or release a sleeping channel. It powers down channels one at a time and then all together. A wrong bias term would leave the shared bias running with every channel asleep, or gate it when only one channel sleeps. It wakes a channel whose lock flag stayed high through the power-down. A design without the reacquire rule would report that channel locked at once. Every case is sampled three edges after the change, so an extra or missing pipeline stage appears as a mismatch.

// File: rtl/outctl_pkg.sv
package outctl_pkg;

  typedef struct packed {
    logic dout_en;
    logic force_hi;
    logic lock_en;
    logic lock_val;
  } chan_ctl_t;

  localparam chan_ctl_t CTL_SLEEP = '{dout_en: 1'b1, force_hi: 1'b1, lock_en: 1'b1, lock_val: 1'b1};
  localparam chan_ctl_t CTL_SCAN  = '{dout_en: 1'b0, force_hi: 1'b0, lock_en: 1'b0, lock_val: 1'b1};

endpackage

// File: rtl/outctl_sync.sv
module outctl_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) st_q[k] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/outctl_chan.sv
module outctl_chan
  import outctl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      scan_i,
  input  logic      mst_sleep_i,
  input  logic      ch_sleep_i,
  input  logic      oe_i,
  input  logic      locked_i,
  output chan_ctl_t ctl_o,
  output logic      pd_o
);

  chan_ctl_t ctl_d, ctl_q;
  logic pd_c, rise_c, held_d, held_q, lock_prev_q, lock_eff;

  assign pd_c   = mst_sleep_i | ch_sleep_i;
  assign rise_c = locked_i & ~lock_prev_q;

  // lock reacquire gate after power-down
  always_comb begin
    if (pd_c)        held_d = 1'b1;
    else if (rise_c) held_d = 1'b0;
    else             held_d = held_q;
  end

  assign lock_eff = locked_i & ~held_d;

  always_comb begin
    if (scan_i) begin
      ctl_d = CTL_SCAN;
    end else if (pd_c) begin
      ctl_d = CTL_SLEEP;
    end else begin
      ctl_d.dout_en  = oe_i;
      ctl_d.force_hi = ~lock_eff;
      ctl_d.lock_en  = 1'b1;
      ctl_d.lock_val = ~lock_eff;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q       <= CTL_SLEEP;
      pd_o        <= 1'b1;
      held_q      <= 1'b1;
      lock_prev_q <= 1'b0;
    end else begin
      ctl_q       <= ctl_d;
      pd_o        <= pd_c;
      held_q      <= held_d;
      lock_prev_q <= locked_i;
    end
  end

  assign ctl_o = ctl_q;

  AST_PD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_c |=> held_q); // R11

  AST_CH_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_i && pd_c) |=> (ctl_q.force_hi && ctl_q.lock_val && ctl_q.dout_en)); // R4

  AST_OE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_i && !pd_c && !oe_i) |=> (ctl_q.lock_en && !ctl_q.dout_en)); // R5

endmodule

// File: rtl/outctl_prio.sv
module outctl_prio
  import outctl_pkg::*;
#(
  parameter int unsigned NUM_CH      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_hiz_ni,
  input  logic              scan_bist_i,
  input  logic              mst_pwr_ni,
  input  logic [NUM_CH-1:0] ch_pwr_ni,
  input  logic              out_en_i,
  input  logic [NUM_CH-1:0] lock_det_i,
  output logic [NUM_CH-1:0] dat_oe_o,
  output logic [NUM_CH-1:0] dat_hi_o,
  output logic [NUM_CH-1:0] lck_oe_o,
  output logic [NUM_CH-1:0] lck_o,
  output logic [NUM_CH-1:0] ch_pd_o,
  output logic              bias_pd_o
);

  localparam int unsigned SYNC_W = 4 + 2 * NUM_CH;
  // high-Z request idles high, everything else idles low
  localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << (SYNC_W - 1);

  logic [SYNC_W-1:0] raw_c, syn_c;
  logic              hiz_n_s, bist_s, mst_n_s, oe_s;
  logic [NUM_CH-1:0] pwr_n_s, lock_s;
  logic              scan_c, mst_sleep_c;

  assign raw_c = {scan_hiz_ni, scan_bist_i, mst_pwr_ni, out_en_i, ch_pwr_ni, lock_det_i};

  outctl_sync #(
    .W      (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_c),
    .q_o   (syn_c)
  );

  assign {hiz_n_s, bist_s, mst_n_s, oe_s, pwr_n_s, lock_s} = syn_c;

  assign scan_c      = ~hiz_n_s | bist_s;
  assign mst_sleep_c = ~mst_n_s;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    chan_ctl_t ctl;

    outctl_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .scan_i     (scan_c),
      .mst_sleep_i(mst_sleep_c),
      .ch_sleep_i (~pwr_n_s[g]),
      .oe_i       (oe_s),
      .locked_i   (lock_s[g]),
      .ctl_o      (ctl),
      .pd_o       (ch_pd_o[g])
    );

    assign dat_oe_o[g] = ctl.dout_en;
    assign dat_hi_o[g] = ctl.force_hi;
    assign lck_oe_o[g] = ctl.lock_en;
    assign lck_o[g]    = ctl.lock_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bias_pd_o <= 1'b1;
    else         bias_pd_o <= mst_sleep_c | (pwr_n_s == '0);
  end

  AST_SCAN_TRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_c |=> (dat_oe_o == '0 && lck_oe_o == '0)); // R2

  AST_MST_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_c && mst_sleep_c) |=> (dat_hi_o == '1 && lck_o == '1 && ch_pd_o == '1)); // R3

  AST_BIAS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_n_s == '0) |=> bias_pd_o); // R8

endmodule

// File: tb/outctl_prio_test.sv
module outctl_prio_test;
  localparam int N = 6;

  typedef struct {
    bit         hiz_n, bist, mst_n, oe;
    bit [N-1:0] pwr_n, lk;
  } snap_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scan_hiz_n = 1'b1, scan_bist = 1'b0, mst_pwr_n = 1'b0, out_en = 1'b0;
  logic [N-1:0] ch_pwr_n = '0, lock_det = '0;
  logic [N-1:0] dat_oe, dat_hi, lck_oe, lck, ch_pd;
  logic bias_pd;

  int checks = 0, fails = 0;
  bit run = 0;
  snap_t q[$];
  bit [N-1:0] held = '1, prev = '0;

  always #10 clk = ~clk;

  outctl_prio #(.NUM_CH(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scan_hiz_ni(scan_hiz_n), .scan_bist_i(scan_bist),
    .mst_pwr_ni(mst_pwr_n), .ch_pwr_ni(ch_pwr_n), .out_en_i(out_en), .lock_det_i(lock_det),
    .dat_oe_o(dat_oe), .dat_hi_o(dat_hi), .lck_oe_o(lck_oe), .lck_o(lck),
    .ch_pd_o(ch_pd), .bias_pd_o(bias_pd)
  );

  task automatic chk(string tag, string what, int ch, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s ch%0d actual=%b expected=%b t=%0t", tag, what, ch, act, exp, $time);
    end
  endtask

  function automatic snap_t dflt();
    snap_t s;
    s.hiz_n = 1; s.bist = 0; s.mst_n = 0; s.oe = 0; s.pwr_n = '0; s.lk = '0;
    return s;
  endfunction

  always @(posedge clk) if (run) begin
    snap_t s;
    s.hiz_n = scan_hiz_n; s.bist = scan_bist; s.mst_n = mst_pwr_n; s.oe = out_en;
    s.pwr_n = ch_pwr_n; s.lk = lock_det;
    q.push_back(s);
  end

  // outputs reflect the sample taken three edges earlier (R1)
  task automatic cyc();
    snap_t s;
    bit scan, pd, eff;
    string tag;
    @(negedge clk);
    s = q.pop_front();
    scan = !s.hiz_n || s.bist;
    for (int i = 0; i < N; i++) begin
      pd = !s.mst_n || !s.pwr_n[i];
      if (pd) held[i] = 1;
      else if (s.lk[i] && !prev[i]) held[i] = 0;
      prev[i] = s.lk[i];
      eff = s.lk[i] && !held[i];
      if (scan) begin
        tag = "R2";
        chk(tag, "dat_oe", i, dat_oe[i], 0); chk(tag, "lck_oe", i, lck_oe[i], 0);
        chk(tag, "dat_hi", i, dat_hi[i], 0); chk(tag, "lck", i, lck[i], 1);
      end else if (pd) begin
        tag = !s.mst_n ? "R3" : "R4";
        chk(tag, "dat_oe", i, dat_oe[i], 1); chk(tag, "lck_oe", i, lck_oe[i], 1);
        chk(tag, "dat_hi", i, dat_hi[i], 1); chk(tag, "lck", i, lck[i], 1);
      end else begin
        tag = (s.lk[i] && held[i]) ? "R11" : (!s.oe ? "R5" : "R6");
        chk(tag, "dat_oe", i, dat_oe[i], s.oe); chk(tag, "lck_oe", i, lck_oe[i], 1);
        chk(tag, "dat_hi", i, dat_hi[i], !eff); chk(tag, "lck", i, lck[i], !eff);
      end
      chk("R7", "ch_pd", i, ch_pd[i], pd);
    end
    chk("R8", "bias_pd", 0, bias_pd, !s.mst_n || s.pwr_n == '0);
  endtask

  task automatic cycles(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    q.push_back(dflt());
    q.push_back(dflt());
    repeat (3) @(negedge clk);
    // R9: reset state with defaults
    for (int i = 0; i < N; i++) begin
      chk("R9", "dat_hi", i, dat_hi[i], 1); chk("R9", "lck", i, lck[i], 1);
      chk("R9", "ch_pd", i, ch_pd[i], 1);
    end
    chk("R9", "bias_pd", 0, bias_pd, 1);
    rst_n = 1'b1;
    run = 1;
    cycles(5);                                   // R9 idle sleep after reset
    mst_pwr_n = 1; cycles(5);                    // R8: master up, all channels still down
    ch_pwr_n = '1; out_en = 1; cycles(5);        // R6 unlocked
    lock_det = 6'b010101; cycles(5);             // R6 locked channels
    out_en = 0; cycles(5);                       // R5 lock still reported
    out_en = 1; cycles(5);                       // R10 resume
    out_en = 0; cycles(1); out_en = 1; cycles(6); // R1 single-cycle pulse
    lock_det[1] = 1; cycles(4);
    ch_pwr_n[1] = 0; cycles(5);                  // R4, R7
    ch_pwr_n[1] = 1; cycles(6);                  // R11 lock high through power-down
    lock_det[1] = 0; cycles(3);
    lock_det[1] = 1; cycles(5);                  // R11 reacquired
    scan_hiz_n = 0; cycles(5);                   // R2 high-Z
    scan_hiz_n = 1; scan_bist = 1; mst_pwr_n = 0; cycles(5); // R2 over master, R7
    scan_bist = 0; cycles(5);                    // R3
    mst_pwr_n = 1; ch_pwr_n = '0; cycles(5);     // R8 all channel power-downs
    ch_pwr_n = 6'b000001; cycles(5);             // R8 one awake
    ch_pwr_n = '1; lock_det = '0; cycles(3);
    lock_det = '1; out_en = 0; cycles(6);        // R5, R11
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule